// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter. Software programs one control word that selects the analog input channel, the bit-period source, the result alignment, the interrupt enable and the module enable. It launches a conversion by writing the start bit. While the conversion runs, the block drives a trial code to an external DAC, holds the sample-and-hold switch open, and reads back a single comparator bit. The comparator bit is high when the held input is at or above the DAC output. The block then resolves the code one bit per bit period, most significant bit first.

One conversion lasts twelve bit periods. The first opens the sample switch, the next ten each decide one bit, and the last stores the code in a 16-bit result word and raises a completion flag. The start bit reads back as the busy indicator and drops by itself when the result is ready, so software can poll it. After each completion a two-bit-period recovery window follows, and start requests are refused during that window. The bit period comes from the system clock divided by 2, 8 or 32. It can also be counted from pulses on a separate slow-tick enable input, so the whole design runs on one clock.

Top module: `sar_adc_seq`

## Requirements
- R1: After synchronous reset, go_busy_o, hold_o, flag_o, irq_o, chan_o, dac_code_o and result_o are all zero.
- R2: During a conversion, dac_code_o shows the trial code: 0 in bit period 1, 512 (MSB set) in period 2, and in each following period one more decided bit. A trial bit is kept only if comp_i was 1 at the end of the period that tried it. Outside a conversion dac_code_o is 0.
- R3: reg_wdata[5:4] selects the bit period: 0 gives 2 clocks, 1 gives 8 clocks, 2 gives 32 clocks, and 3 gives one slow_tick_i pulse. An accepted start holds go_busy_o high for exactly 12 bit periods after the write edge.
- R4: A write with reg_wdata[0] (enable) and reg_wdata[1] (go) both set starts a conversion while idle. go_busy_o clears by itself at completion, and hold_o is high exactly while go_busy_o is high.
- R5: At completion result_o takes the code right-justified in bits 9:0 when reg_wdata[2] was 1, or left-justified in bits 15:6 when it was 0. All other result bits are zero.
- R6: flag_o sets on the same edge that go_busy_o falls at completion. A write with reg_wdata[9]=1 clears it, but completion takes priority over a clear in the same cycle.
- R7: irq_o is high exactly when flag_o is high and the interrupt enable reg_wdata[3] was last written as 1.
- R8: For 2 bit periods after a completion, a start write is ignored and go_busy_o stays 0. A start written after that window is accepted.
- R9: A write with go=0 during a conversion aborts it on the next edge: go_busy_o and dac_code_o return to 0, result_o is unchanged and flag_o is not set.
- R10: A write with enable=0 ignores the go bit, aborts any running conversion as in R9 and clears the recovery window.
- R11: chan_o shows reg_wdata[8:6] from the last register write, to steer the external analog multiplexer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 10 | Control word: [0] enable, [1] go, [2] right-justify, [3] irq enable, [5:4] bit-period select, [8:6] channel, [9] flag clear |
| slow_tick_i | input | 1 | Slow bit-period clock enable pulse (select 3) |
| comp_i | input | 1 | Comparator: 1 when held input is at or above the DAC output |
| go_busy_o | output | 1 | Start bit readback, high while converting |
| hold_o | output | 1 | Sample switch open (hold) during conversion |
| chan_o | output | 3 | Analog multiplexer channel |
| dac_code_o | output | 10 | Trial code for the external DAC |
| result_o | output | 16 | Justified conversion result |
| flag_o | output | 1 | Completion flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A write is captured at one rising edge, and its register effects (channel, enable, flag clear, start or abort) show on the outputs after that same edge. The trial code advances one edge after each bit-period boundary. go_busy_o falls, flag_o rises and result_o loads together, 12 bit periods of edges after the start edge. The bench keeps a behavioural reference that advances on every rising edge from the same inputs, and it compares all outputs at the following falling edge. The directed checks count falling edges from the write, so the busy length of 24, 96 and 384 cycles, the refused start inside the recovery window and the accepted start just after it are each sampled in the cycle the rules fix.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int CHAN_W = 3;
  localparam int SEL_W  = 2;

  // control word, bit 0 first: enable, go, right_just, irq_en, tad_sel, chan, flag_clr
  typedef struct packed {
    logic              flag_clr;
    logic [CHAN_W-1:0] chan;
    logic [SEL_W-1:0]  tad_sel;
    logic              irq_en;
    logic              right_just;
    logic              go;
    logic              en;
  } ctrl_word_t;

  localparam int CTRL_W = $bits(ctrl_word_t);
  localparam logic [SEL_W-1:0] SEL_SLOW = 2'd3;
endpackage

// File: rtl/sar_tad_gen.sv
module sar_tad_gen #(
  parameter int DIV0 = 2,
  parameter int DIV1 = 8,
  parameter int DIV2 = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  input  logic       slow_tick_i,
  output logic       tick_o
);
  localparam int MAXD01 = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int MAXD   = (MAXD01 > DIV2) ? MAXD01 : DIV2;
  localparam int CNT_W  = (MAXD > 2) ? $clog2(MAXD) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    case (sel_i)
      2'd0:    lim = CNT_W'(DIV0 - 1);
      2'd1:    lim = CNT_W'(DIV1 - 1);
      default: lim = CNT_W'(DIV2 - 1);
    endcase
  end

  assign tick_o = run_i && ((sel_i == sar_pkg::SEL_SLOW) ? slow_tick_i : (cnt_q == lim));

  always_ff @(posedge clk) begin
    if (rst || !run_i || tick_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // divided periods are at least two clocks long
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_o && sel_i != sar_pkg::SEL_SLOW) |=> (!tick_o || sel_i == sar_pkg::SEL_SLOW));
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int RES = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic           abort_i,
  input  logic           tick_i,
  input  logic           comp_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [RES-1:0] code_o
);
  localparam int IDX_W = $clog2(RES + 2);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(RES + 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES-1:0]   sar_q;
  logic [RES-1:0]   sar_nxt;

  // decide bit (RES - idx), then try the bit below it
  always_comb begin
    int bp;
    bp = RES - int'(idx_q);
    for (int i = 0; i < RES; i++) begin
      sar_nxt[i] = sar_q[i];
      if (i == bp)          sar_nxt[i] = comp_i;
      else if (i + 1 == bp) sar_nxt[i] = 1'b1;
    end
  end

  assign done_o = busy_q && tick_i && (idx_q == LAST) && !abort_i;

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sar_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      sar_q  <= '0;
    end else if (busy_q && tick_i) begin
      if (idx_q == '0) begin
        sar_q <= {1'b1, {(RES-1){1'b0}}};
        idx_q <= idx_q + 1'b1;
      end else if (idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
        sar_q  <= '0;
      end else begin
        sar_q <= sar_nxt;
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign code_o = sar_q;

  assert_msb_first_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_q && tick_i && idx_q == '0 && !abort_i) |=> (code_o == {1'b1, {(RES-1){1'b0}}}));
  assert_idle_code_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (code_o == '0));
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int RES   = 10,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             right_i,
  input  logic [RES-1:0]   code_i,
  output logic [OUT_W-1:0] result_o
);
  localparam int PAD = OUT_W - RES;

  logic [OUT_W-1:0] res_q;

  always_ff @(posedge clk) begin
    if (rst)
      res_q <= '0;
    else if (load_i)
      res_q <= right_i ? {{PAD{1'b0}}, code_i} : {code_i, {PAD{1'b0}}};
  end

  assign result_o = res_q;

  assert_right_pad_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (load_i && right_i) |=> (result_o[OUT_W-1:RES] == '0));
  assert_left_pad_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (load_i && !right_i) |=> (result_o[PAD-1:0] == '0));
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int RES       = 10,
  parameter int OUT_W     = 16,
  parameter int DIV0      = 2,
  parameter int DIV1      = 8,
  parameter int DIV2      = 32,
  parameter int HOLD_TADS = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_we,
  input  logic [sar_pkg::CTRL_W-1:0] reg_wdata,
  input  logic                       slow_tick_i,
  input  logic                       comp_i,
  output logic                       go_busy_o,
  output logic                       hold_o,
  output logic [sar_pkg::CHAN_W-1:0] chan_o,
  output logic [RES-1:0]             dac_code_o,
  output logic [OUT_W-1:0]           result_o,
  output logic                       flag_o,
  output logic                       irq_o
);
  import sar_pkg::*;

  localparam int HW = $clog2(HOLD_TADS + 1);

  ctrl_word_t       wr;
  logic             en_q, rj_q, ie_q, flag_q;
  logic [SEL_W-1:0] sel_q;
  logic [CHAN_W-1:0] chan_q;
  logic [HW-1:0]    hold_q;
  logic             busy, done, tick, start, abort, run;
  logic [RES-1:0]   code;

  assign wr    = ctrl_word_t'(reg_wdata);
  assign abort = reg_we && busy && (!wr.en || !wr.go);
  assign start = reg_we && wr.en && wr.go && !busy && (hold_q == '0);
  assign run   = busy || (hold_q != '0);

  sar_tad_gen #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_tad (
    .clk(clk), .rst(rst), .run_i(run), .sel_i(sel_q),
    .slow_tick_i(slow_tick_i), .tick_o(tick)
  );

  sar_core #(.RES(RES)) u_core (
    .clk(clk), .rst(rst), .start_i(start), .abort_i(abort), .tick_i(tick),
    .comp_i(comp_i), .busy_o(busy), .done_o(done), .code_o(code)
  );

  sar_result #(.RES(RES), .OUT_W(OUT_W)) u_res (
    .clk(clk), .rst(rst), .load_i(done), .right_i(rj_q),
    .code_i(code), .result_o(result_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; rj_q <= 1'b0; ie_q <= 1'b0;
      sel_q <= '0; chan_q <= '0;
    end else if (reg_we) begin
      en_q <= wr.en; rj_q <= wr.right_just; ie_q <= wr.irq_en;
      sel_q <= wr.tad_sel; chan_q <= wr.chan;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    hold_q <= '0;
    else if (reg_we && !wr.en)  hold_q <= '0;
    else if (done)              hold_q <= HW'(HOLD_TADS);
    else if (tick && hold_q != '0) hold_q <= hold_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                         flag_q <= 1'b0;
    else if (done)                   flag_q <= 1'b1;
    else if (reg_we && wr.flag_clr)  flag_q <= 1'b0;
  end

  assign go_busy_o  = busy;
  assign hold_o     = busy;
  assign chan_o     = chan_q;
  assign dac_code_o = code;
  assign flag_o     = flag_q;
  assign irq_o      = flag_q && ie_q;

  assert_done_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> (flag_o && !go_busy_o));
  assert_holdoff_blocks_start_R8: assert property (@(posedge clk) disable iff (rst)
    (hold_q != '0) |=> !$rose(go_busy_o));
  assert_abort_keeps_result_R9: assert property (@(posedge clk) disable iff (rst)
    abort |=> ($stable(result_o) && !go_busy_o && !$rose(flag_o)));
  assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !go_busy_o);
endmodule

// File: tb/sar_adc_seq_tb.sv
module sar_adc_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [9:0]  wd = '0;
  logic        slow_tick = 1'b0;
  logic        comp;
  logic        go, hold, flag, irq;
  logic [2:0]  chan;
  logic [9:0]  dac;
  logic [15:0] res;

  int vin = 0;
  int checks = 0, fails = 0, cyc = 0, sc = 0;
  bit done_flag = 0;

  // reference model state
  int m_busy, m_tad, m_sub, m_hold, m_flag, m_res, m_en, m_rj, m_ie, m_sel, m_ch;

  always #4 clk = ~clk;

  assign comp = (vin >= int'(dac));

  sar_adc_seq u_dut (
    .clk(clk), .rst(rst), .reg_we(we), .reg_wdata(wd), .slow_tick_i(slow_tick),
    .comp_i(comp), .go_busy_o(go), .hold_o(hold), .chan_o(chan),
    .dac_code_o(dac), .result_o(res), .flag_o(flag), .irq_o(irq)
  );

  function automatic int div_of(int s);
    return (s == 0) ? 2 : (s == 1) ? 8 : 32;
  endfunction

  function automatic int exp_dac();
    int b;
    if (!m_busy || m_tad == 0) return 0;
    if (m_tad == 11) return vin;
    b = 10 - m_tad;
    return ((vin >> (b + 1)) << (b + 1)) | (1 << b);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    int act, tk, abrt, strt, dn;
    if (rst) begin
      m_busy = 0; m_tad = 0; m_sub = 0; m_hold = 0; m_flag = 0; m_res = 0;
      m_en = 0; m_rj = 0; m_ie = 0; m_sel = 0; m_ch = 0;
    end else begin
      act  = (m_busy != 0 || m_hold > 0);
      tk   = act && ((m_sel == 3) ? int'(slow_tick) : (m_sub == div_of(m_sel) - 1));
      abrt = we && m_busy && (!wd[0] || !wd[1]);
      strt = we && wd[0] && wd[1] && !m_busy && m_hold == 0;
      dn   = m_busy && tk && m_tad == 11 && !abrt;
      m_sub = (!act || tk) ? 0 : m_sub + 1;
      if (we && !wd[0]) m_hold = 0;
      else if (dn) m_hold = 2;
      else if (tk && m_hold > 0) m_hold--;
      if (abrt) begin m_busy = 0; m_tad = 0; end
      else if (strt) begin m_busy = 1; m_tad = 0; end
      else if (m_busy && tk) begin
        if (m_tad == 11) begin m_busy = 0; m_tad = 0; end
        else m_tad++;
      end
      if (dn) begin
        m_flag = 1;
        m_res = m_rj ? vin : (vin << 6);
      end else if (we && wd[9]) m_flag = 0;
      if (we) begin
        m_en = wd[0]; m_rj = wd[2]; m_ie = wd[3]; m_sel = int'(wd[5:4]); m_ch = int'(wd[8:6]);
      end
    end
  end

  // per-cycle comparison and watchdog
  always @(negedge clk) begin
    cyc++;
    if (!rst && !done_flag) begin
      chk(int'(go) == m_busy, "R4 go_busy", int'(go), m_busy);
      chk(int'(hold) == m_busy, "R4 hold", int'(hold), m_busy);
      chk(int'(dac) == exp_dac(), "R2 dac_code", int'(dac), exp_dac());
      chk(int'(res) == m_res, "R5 result", int'(res), m_res);
      chk(int'(flag) == m_flag, "R6 flag", int'(flag), m_flag);
      chk(int'(irq) == (m_flag & m_ie), "R7 irq", int'(irq), m_flag & m_ie);
      chk(int'(chan) == m_ch, "R11 chan", int'(chan), m_ch);
    end
    if (cyc > 100000 && !done_flag) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // slow bit-period enable: one pulse every 3 clocks
  always @(negedge clk) begin
    sc = (sc + 1) % 3;
    slow_tick = (sc == 0);
  end

  task automatic wr(input bit en, input bit g, input bit rj, input bit ie,
                    input int sel, input int ch, input bit clr);
    @(negedge clk);
    we = 1'b1;
    wd = {clr, 3'(ch), 2'(sel), ie, rj, g, en};
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (go) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(go == 0 && hold == 0 && flag == 0 && irq == 0, "R1 reset ctl", int'(go), 0);
    chk(chan == 0 && dac == 0 && res == 0, "R1 reset data", int'(res), 0);

    // divide-by-2, right justified, irq enabled
    vin = 677;
    wr(1, 1, 1, 1, 0, 5, 0);
    wait_busy(n);
    chk(n == 24, "R3 length div2", n, 24);
    chk(res == 16'd677, "R5 right justify", int'(res), 677);
    chk(flag == 1, "R6 flag set", int'(flag), 1);
    chk(irq == 1, "R7 irq on", int'(irq), 1);
    chk(chan == 5, "R11 channel", int'(chan), 5);

    // start inside the recovery window is refused
    wr(1, 1, 1, 1, 0, 5, 0);
    chk(go == 0, "R8 start refused", int'(go), 0);
    repeat (4) @(negedge clk);
    vin = 100;
    wr(1, 1, 1, 1, 0, 2, 0);
    chk(go == 1, "R8 start accepted", int'(go), 1);
    wait_busy(n);
    chk(res == 16'd100, "R4 second result", int'(res), 100);

    // flag clear
    repeat (6) @(negedge clk);
    wr(1, 0, 1, 1, 0, 2, 1);
    chk(flag == 0 && irq == 0, "R6 flag cleared", int'(flag), 0);

    // divide-by-8, left justified, full scale, irq disabled
    vin = 1023;
    wr(1, 1, 0, 0, 1, 7, 0);
    wait_busy(n);
    chk(n == 96, "R3 length div8", n, 96);
    chk(res == 16'hFFC0, "R5 left justify", int'(res), 'hFFC0);
    chk(flag == 1 && irq == 0, "R7 irq masked", int'(irq), 0);

    // divide-by-32, zero input
    repeat (70) @(negedge clk);
    vin = 0;
    wr(1, 1, 1, 0, 2, 1, 1);
    wait_busy(n);
    chk(n == 384, "R3 length div32", n, 384);
    chk(res == 0, "R2 zero code", int'(res), 0);

    // slow tick source
    repeat (200) @(negedge clk);
    vin = 1;
    wr(1, 1, 0, 0, 3, 3, 1);
    wait_busy(n);
    chk(n >= 34 && n <= 36, "R3 length slow", n, 36);
    chk(res == 16'h0040, "R5 left lsb", int'(res), 'h40);

    // abort via go=0
    repeat (10) @(negedge clk);
    wr(1, 0, 0, 0, 1, 3, 1);
    vin = 300;
    wr(1, 1, 0, 0, 1, 3, 0);
    repeat (30) @(negedge clk);
    wr(1, 0, 0, 0, 1, 3, 0);
    chk(go == 0 && dac == 0, "R9 abort idle", int'(dac), 0);
    chk(res == 16'h0040, "R9 result kept", int'(res), 'h40);
    chk(flag == 0, "R9 no flag", int'(flag), 0);

    // enable off
    wr(0, 1, 0, 0, 1, 3, 0);
    chk(go == 0, "R10 start ignored", int'(go), 0);
    wr(1, 1, 0, 0, 1, 3, 0);
    repeat (10) @(negedge clk);
    wr(0, 1, 0, 0, 1, 3, 0);
    chk(go == 0 && flag == 0, "R10 disable aborts", int'(go), 0);
    chk(res == 16'h0040, "R10 result kept", int'(res), 'h40);

    // first decided bit: trial MSB after one bit period
    vin = 600;
    wr(1, 1, 1, 0, 1, 4, 0);
    repeat (8) @(negedge clk);
    chk(dac == 10'd512, "R2 msb trial", int'(dac), 512);
    repeat (8) @(negedge clk);
    chk(dac == 10'd768, "R2 msb kept", int'(dac), 768);
    wait_busy(n);
    chk(res == 16'd600, "R2 final code", int'(res), 600);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule